// File: doc/BRIEF.md
# Multi-ring receive descriptor flow control

This block watches up to eight circular rings of receive buffer descriptors and tells the link layer when to pause the far end. For each ring, software programs a ring length and a minimum free-descriptor threshold, and keeps a pointer to the last descriptor it has handed back to hardware. The receive engine presents, for every ring, the index of the descriptor it will consume next. From the two pointers and the ring length the block derives each ring's free-descriptor count every cycle and compares it against that ring's threshold.

A global enable turns the whole function on or off, and a per-ring active mask selects which rings take part. While enabled, a registered pause request is raised when any active ring is short of free descriptors and released only once every active ring is back at or above its threshold. A per-ring "below threshold" vector shows which rings caused the pause. Length and threshold updates are refused while the function is enabled and frames are arriving, and a refused update leaves a sticky error flag.

Top module: `rx_ring_pause_ctrl`

## Requirements
- R1: After reset, `pause_req`, `below_thr` and `cfg_err` are all zero, and every stored length, threshold and last-free pointer is zero.
- R2: A ring's free count is (last-free pointer minus consume pointer) modulo the ring length, in the range 0 to length-1, for lengths 1 to 255 and pointers below the length; a ring with length 0 has a free count of 0.
- R3: Bit i of `below_thr` is 1 one cycle after ring i is active and its free count is strictly less than its threshold; a free count equal to the threshold gives 0. The vector reports this whether `lfc_en` is set or not.
- R4: While `lfc_en` is 1, `pause_req` becomes 1 on the clock edge after any active ring's free count drops below its threshold.
- R5: `pause_req` stays 1 while any active ring remains below its threshold, and returns to 0 on the clock edge after every active ring is at or above its threshold.
- R6: A ring whose `ring_active` bit is 0 has no effect on `pause_req` or on `below_thr`, however short it is.
- R7: When `lfc_en` is 0, `pause_req` is 0 from the next clock edge on.
- R8: A length/threshold write (`cfg_we`) that arrives while `lfc_en` and `rx_busy` are both 1 is dropped, and sets `cfg_err`, which then stays 1 until reset.
- R9: A length/threshold write at any other time updates ring `cfg_ring` at the next clock edge; last-free pointer writes (`lf_we`) are always accepted, also while enabled and receiving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lfc_en | input | 1 | Global enable of the flow-control function |
| rx_busy | input | 1 | Receive engine is currently taking in frames |
| ring_active | input | NUM_RINGS | Per-ring participation mask |
| cfg_we | input | 1 | Write strobe for ring length and threshold |
| cfg_ring | input | RING_W | Ring selected by a length/threshold write |
| cfg_len | input | IDX_W | Ring length to store |
| cfg_thr | input | IDX_W | Free-descriptor threshold to store |
| lf_we | input | 1 | Write strobe for a last-free pointer |
| lf_ring | input | RING_W | Ring selected by a last-free pointer write |
| lf_ptr | input | IDX_W | New last-free descriptor index |
| cons_ptr | input | NUM_RINGS*IDX_W | Next-to-consume index per ring, ring i in bits i*IDX_W upward |
| pause_req | output | 1 | Registered level-sensitive pause request |
| below_thr | output | NUM_RINGS | Registered per-ring below-threshold status |
| cfg_err | output | 1 | Sticky flag for a refused length/threshold write |

## Verification
The range assertion on the free count relies on both pointers of a ring being smaller than its programmed length, so the receive engine and software are assumed never to present an index outside the ring; every stimulus vector and directed step keeps pointers below the length, and the zero-length case is only driven with the ring's own check in mind. The drop assertion assumes the write strobe is a single clean cycle, which the bench's write tasks guarantee. Length and threshold changes in the bench are made with the enable clear or the receive engine idle, except in the one step that deliberately provokes a refused write.

// File: rtl/rxfc_pkg.sv
`timescale 1ns/1ps
package rxfc_pkg;
    localparam int DEF_RINGS = 8;
    localparam int DEF_IDX_W = 8;

    // outcome of a length/threshold write attempt
    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_TAKEN   = 2'd1,
        WR_DROPPED = 2'd2
    } wr_outcome_e;
endpackage

// File: rtl/rxfc_ring_cfg.sv
`timescale 1ns/1ps
module rxfc_ring_cfg
    import rxfc_pkg::*;
#(
    parameter int NUM_RINGS = DEF_RINGS,
    parameter int IDX_W     = DEF_IDX_W,
    localparam int RING_W   = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              lfc_en,
    input  logic                              rx_busy,
    input  logic                              cfg_we,
    input  logic [RING_W-1:0]                 cfg_ring,
    input  logic [IDX_W-1:0]                  cfg_len,
    input  logic [IDX_W-1:0]                  cfg_thr,
    input  logic                              lf_we,
    input  logic [RING_W-1:0]                 lf_ring,
    input  logic [IDX_W-1:0]                  lf_ptr,
    output logic [NUM_RINGS-1:0][IDX_W-1:0]   len_o,
    output logic [NUM_RINGS-1:0][IDX_W-1:0]   thr_o,
    output logic [NUM_RINGS-1:0][IDX_W-1:0]   lf_o,
    output logic                              err_o
);
    typedef struct packed {
        logic [NUM_RINGS-1:0][IDX_W-1:0] len;
        logic [NUM_RINGS-1:0][IDX_W-1:0] thr;
        logic [NUM_RINGS-1:0][IDX_W-1:0] lf;
        logic                            err;
    } cfg_state_t;

    cfg_state_t  st_d, st_q;
    wr_outcome_e outcome;

    always_comb begin
        st_d    = st_q;
        outcome = WR_NONE;
        if (cfg_we && (int'(cfg_ring) < NUM_RINGS)) begin
            if (lfc_en && rx_busy) begin
                outcome = WR_DROPPED;
            end else begin
                outcome = WR_TAKEN;
            end
        end
        case (outcome)
            WR_TAKEN: begin
                st_d.len[cfg_ring] = cfg_len;
                st_d.thr[cfg_ring] = cfg_thr;
            end
            WR_DROPPED: st_d.err = 1'b1;
            default: ;
        endcase
        if (lf_we && (int'(lf_ring) < NUM_RINGS)) begin
            st_d.lf[lf_ring] = lf_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_o = st_q.len;
    assign thr_o = st_q.thr;
    assign lf_o  = st_q.lf;
    assign err_o = st_q.err;

    // R8: a refused write leaves lengths and thresholds untouched and flags it
    a_r8_drop_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lfc_en && rx_busy) |=> ($stable(len_o) && $stable(thr_o) && err_o));

    // R8: the error flag never clears on its own
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

// File: rtl/rxfc_free_calc.sv
`timescale 1ns/1ps
module rxfc_free_calc
    import rxfc_pkg::*;
#(
    parameter int IDX_W = DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] len_i,
    input  logic [IDX_W-1:0] thr_i,
    input  logic [IDX_W-1:0] lf_i,
    input  logic [IDX_W-1:0] cons_i,
    input  logic             active_i,
    output logic [IDX_W-1:0] free_o,
    output logic             below_o
);
    logic [IDX_W:0] diff;
    logic [IDX_W:0] wrapped;

    always_comb begin
        diff    = {1'b0, lf_i} - {1'b0, cons_i};
        wrapped = diff + {1'b0, len_i};
        if (len_i == '0) begin
            free_o = '0;
        end else if (diff[IDX_W]) begin
            free_o = wrapped[IDX_W-1:0];
        end else begin
            free_o = diff[IDX_W-1:0];
        end
        below_o = active_i && (free_o < thr_i);
    end

    // R2: with in-range pointers the free count stays below the ring length
    a_r2_free_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((len_i != '0) && (lf_i < len_i) && (cons_i < len_i)) |-> (free_o < len_i));

    // R6: an inactive ring never reports a shortage
    a_r6_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> !below_o);
endmodule

// File: rtl/rxfc_pause_reg.sv
`timescale 1ns/1ps
module rxfc_pause_reg
    import rxfc_pkg::*;
#(
    parameter int NUM_RINGS = DEF_RINGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lfc_en,
    input  logic [NUM_RINGS-1:0] below_i,
    output logic                 pause_o,
    output logic [NUM_RINGS-1:0] below_o
);
    typedef struct packed {
        logic                 pause;
        logic [NUM_RINGS-1:0] below;
    } pause_state_t;

    pause_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.below = below_i;
        st_d.pause = lfc_en && (|below_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pause_o = st_q.pause;
    assign below_o = st_q.below;

    // R4: a shortage on any active ring raises the request next cycle
    a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (lfc_en && (|below_i)) |=> pause_o);

    // R5: once all active rings recover the request is released next cycle
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (lfc_en && !(|below_i)) |=> !pause_o);

    // R7: a cleared enable forces the request low next cycle
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !lfc_en |=> !pause_o);
endmodule

// File: rtl/rx_ring_pause_ctrl.sv
`timescale 1ns/1ps
module rx_ring_pause_ctrl
    import rxfc_pkg::*;
#(
    parameter int NUM_RINGS = DEF_RINGS,
    parameter int IDX_W     = DEF_IDX_W,
    localparam int RING_W   = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lfc_en,
    input  logic                       rx_busy,
    input  logic [NUM_RINGS-1:0]       ring_active,
    input  logic                       cfg_we,
    input  logic [RING_W-1:0]          cfg_ring,
    input  logic [IDX_W-1:0]           cfg_len,
    input  logic [IDX_W-1:0]           cfg_thr,
    input  logic                       lf_we,
    input  logic [RING_W-1:0]          lf_ring,
    input  logic [IDX_W-1:0]           lf_ptr,
    input  logic [NUM_RINGS*IDX_W-1:0] cons_ptr,
    output logic                       pause_req,
    output logic [NUM_RINGS-1:0]       below_thr,
    output logic                       cfg_err
);
    logic [NUM_RINGS-1:0][IDX_W-1:0] len_v;
    logic [NUM_RINGS-1:0][IDX_W-1:0] thr_v;
    logic [NUM_RINGS-1:0][IDX_W-1:0] lf_v;
    logic [NUM_RINGS-1:0][IDX_W-1:0] free_v;
    logic [NUM_RINGS-1:0]            short_v;

    rxfc_ring_cfg #(.NUM_RINGS(NUM_RINGS), .IDX_W(IDX_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .lfc_en   (lfc_en),
        .rx_busy  (rx_busy),
        .cfg_we   (cfg_we),
        .cfg_ring (cfg_ring),
        .cfg_len  (cfg_len),
        .cfg_thr  (cfg_thr),
        .lf_we    (lf_we),
        .lf_ring  (lf_ring),
        .lf_ptr   (lf_ptr),
        .len_o    (len_v),
        .thr_o    (thr_v),
        .lf_o     (lf_v),
        .err_o    (cfg_err)
    );

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        rxfc_free_calc #(.IDX_W(IDX_W)) u_calc (
            .clk      (clk),
            .rst_n    (rst_n),
            .len_i    (len_v[g]),
            .thr_i    (thr_v[g]),
            .lf_i     (lf_v[g]),
            .cons_i   (cons_ptr[g*IDX_W +: IDX_W]),
            .active_i (ring_active[g]),
            .free_o   (free_v[g]),
            .below_o  (short_v[g])
        );
    end

    rxfc_pause_reg #(.NUM_RINGS(NUM_RINGS)) u_pause (
        .clk      (clk),
        .rst_n    (rst_n),
        .lfc_en   (lfc_en),
        .below_i  (short_v),
        .pause_o  (pause_req),
        .below_o  (below_thr)
    );

    // R3: status bits only ever name active rings
    a_r3_status_active: assert property (@(posedge clk) disable iff (!rst_n)
        ((below_thr & ~$past(ring_active)) == '0));
endmodule

// File: tb/tb_rx_ring_pause_ctrl.sv
`timescale 1ns/1ps
module tb_rx_ring_pause_ctrl;
    localparam int N = 8;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lfc_en = 1'b0;
    logic         rx_busy = 1'b1;
    logic [N-1:0] ring_active = '0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_ring = '0;
    logic [W-1:0] cfg_len = '0;
    logic [W-1:0] cfg_thr = '0;
    logic         lf_we = 1'b0;
    logic [2:0]   lf_ring = '0;
    logic [W-1:0] lf_ptr = '0;
    logic [N*W-1:0] cons_ptr = '0;
    logic         pause_req;
    logic [N-1:0] below_thr;
    logic         cfg_err;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    rx_ring_pause_ctrl #(.NUM_RINGS(N), .IDX_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .lfc_en(lfc_en), .rx_busy(rx_busy),
        .ring_active(ring_active), .cfg_we(cfg_we), .cfg_ring(cfg_ring),
        .cfg_len(cfg_len), .cfg_thr(cfg_thr), .lf_we(lf_we), .lf_ring(lf_ring),
        .lf_ptr(lf_ptr), .cons_ptr(cons_ptr), .pause_req(pause_req),
        .below_thr(below_thr), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [2:0]   ring;
        logic [W-1:0] len;
        logic [W-1:0] thr;
        logic [W-1:0] lf;
        logic [W-1:0] cons;
        logic         short_exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 8'd16,  8'd4,   8'd10, 8'd3,   1'b0},  // free 7
        '{3'd0, 8'd16,  8'd4,   8'd5,  8'd3,   1'b1},  // free 2
        '{3'd2, 8'd16,  8'd4,   8'd2,  8'd14,  1'b0},  // wrap, free 4 == thr
        '{3'd2, 8'd16,  8'd5,   8'd2,  8'd14,  1'b1},  // wrap, free 4 < 5
        '{3'd7, 8'd200, 8'd50,  8'd10, 8'd100, 1'b0},  // wrap, free 110
        '{3'd7, 8'd200, 8'd120, 8'd10, 8'd100, 1'b1},  // free 110 < 120
        '{3'd5, 8'd8,   8'd1,   8'd3,  8'd3,   1'b1},  // free 0 < 1
        '{3'd5, 8'd8,   8'd0,   8'd3,  8'd3,   1'b0}   // free 0, thr 0
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [2:0] r, input logic [W-1:0] l, input logic [W-1:0] t);
        cfg_we = 1'b1; cfg_ring = r; cfg_len = l; cfg_thr = t;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_lf(input logic [2:0] r, input logic [W-1:0] p);
        lf_we = 1'b1; lf_ring = r; lf_ptr = p;
        @(negedge clk);
        lf_we = 1'b0;
    endtask

    task automatic set_cons(input int r, input logic [W-1:0] p);
        cons_ptr[r*W +: W] = p;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 pause", {31'd0, pause_req}, 32'd0);
        check("R1 below", {24'd0, below_thr}, 32'd0);
        check("R1 err", {31'd0, cfg_err}, 32'd0);
        rx_busy = 1'b0; ring_active = '1; lfc_en = 1'b1;
        tick(2);
        check("R1 zero config no pause", {31'd0, pause_req}, 32'd0);
        rx_busy = 1'b1; lfc_en = 1'b0;

        // R2/R3/R4 vector table, one ring active at a time
        foreach (VECS[i]) begin
            lfc_en = 1'b0;
            ring_active = '0;
            wr_cfg(VECS[i].ring, VECS[i].len, VECS[i].thr);
            wr_lf(VECS[i].ring, VECS[i].lf);
            set_cons(int'(VECS[i].ring), VECS[i].cons);
            ring_active = N'(1) << VECS[i].ring;
            lfc_en = 1'b1;
            tick(2);
            check($sformatf("R2 R3 vec%0d below", i), {24'd0, below_thr},
                  VECS[i].short_exp ? {24'd0, ring_active} : 32'd0);
            check($sformatf("R4 vec%0d pause", i), {31'd0, pause_req},
                  {31'd0, VECS[i].short_exp});
        end

        // R4 exact raise cycle and R5 hold/release
        lfc_en = 1'b0; ring_active = '0;
        wr_cfg(3'd0, 8'd16, 8'd4);
        wr_lf(3'd0, 8'd10);
        set_cons(0, 8'd3);
        ring_active = 8'h01; lfc_en = 1'b1;
        tick(2);
        check("R4 no shortage", {31'd0, pause_req}, 32'd0);
        set_cons(0, 8'd8);               // free 2 < 4
        #1;
        check("R4 not before edge", {31'd0, pause_req}, 32'd0);
        tick(1);
        check("R4 raised after one edge", {31'd0, pause_req}, 32'd1);
        wr_lf(3'd0, 8'd15);              // R9 accepted while enabled and busy; free 7
        check("R5 held until recount", {31'd0, pause_req}, 32'd1);
        tick(1);
        check("R5 released", {31'd0, pause_req}, 32'd0);
        check("R9 lf write while busy", {24'd0, below_thr}, 32'd0);

        // R6 inactive short ring
        rx_busy = 1'b0;
        wr_cfg(3'd3, 8'd16, 8'd10);      // R9 accepted while enabled but idle
        wr_lf(3'd3, 8'd0);
        set_cons(3, 8'd0);               // free 0 < 10
        rx_busy = 1'b1;
        tick(2);
        check("R6 inactive no pause", {31'd0, pause_req}, 32'd0);
        check("R6 inactive no status", {24'd0, below_thr}, 32'd0);
        ring_active = 8'h09;
        tick(2);
        check("R9 cfg taken when idle", {24'd0, below_thr}, 32'h08);
        check("R5 one short ring holds pause", {31'd0, pause_req}, 32'd1);
        check("R8 no error yet", {31'd0, cfg_err}, 32'd0);

        // R7 disable
        lfc_en = 1'b0;
        #1;
        check("R7 before edge", {31'd0, pause_req}, 32'd1);
        tick(1);
        check("R7 cleared", {31'd0, pause_req}, 32'd0);
        check("R3 status while disabled", {24'd0, below_thr}, 32'h08);

        // R8 refused write
        lfc_en = 1'b1; rx_busy = 1'b1;
        wr_cfg(3'd3, 8'd16, 8'd0);
        tick(1);
        check("R8 write dropped", {24'd0, below_thr}, 32'h08);
        check("R8 pause kept", {31'd0, pause_req}, 32'd1);
        check("R8 err set", {31'd0, cfg_err}, 32'd1);
        rx_busy = 1'b0;
        wr_cfg(3'd3, 8'd16, 8'd0);
        tick(1);
        check("R9 write after idle", {24'd0, below_thr}, 32'd0);
        check("R5 all recovered", {31'd0, pause_req}, 32'd0);
        check("R8 err sticky", {31'd0, cfg_err}, 32'd1);

        // R2 zero length ring
        wr_cfg(3'd4, 8'd0, 8'd1);
        wr_lf(3'd4, 8'd5);
        set_cons(4, 8'd3);
        ring_active = 8'h10;
        tick(2);
        check("R2 zero length free 0", {24'd0, below_thr}, 32'h10);
        check("R4 zero length pause", {31'd0, pause_req}, 32'd1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule